// File: doc/BRIEF.md
# Keyboard-Controller Output-Port Command Interface

This block is the host-facing register side of a legacy PC keyboard controller, reduced to the commands that read and write the controller's output port. The host sees two byte-wide locations on one 8-bit bus. The `sel_cmd` input picks the location. A write to the command location is taken as a command byte. A write to the data location is taken as a parameter byte. A read of the command location returns a status byte. A read of the data location returns the byte that waits in the output buffer.

Each accepted byte keeps the controller busy for `CONSUME_CYC` clock cycles. During that time the input-buffer-full flag stays set and the host must hold off. When the busy time ends the byte is executed. Command 0xD0 copies the output port into the output buffer. Command 0xD1 arms the controller, and the next data byte becomes the new output-port value. Two bits of the output port are brought out as registered lines. One is an A20 gate, for an address-masking stage. The other is an active-high CPU reset request.

Top module: `kbc_portctl`

## Requirements
- R1: After synchronous reset the output port is 0xFF, `a20_gate` is 1, `cpu_reset` is 0, and the status byte reads 0x00.
- R2: The status byte has input-buffer-full at bit 1 and output-buffer-full at bit 0, with bits 7..2 at 0. Reading the status location changes no state.
- R3: A write is accepted only while input-buffer-full is 0. After it is accepted, input-buffer-full reads 1 for exactly `CONSUME_CYC` cycles. A write that arrives while the flag is 1 is ignored.
- R4: When command 0xD0 completes, the output buffer is loaded with the current output-port value and output-buffer-full is set.
- R5: A data byte that completes after command 0xD1 becomes the output-port value, on the same edge that clears input-buffer-full.
- R6: Any command byte other than 0xD1 cancels a pending 0xD1. A data byte with no 0xD1 pending leaves the output port unchanged.
- R7: A read of the data location returns the output-buffer byte on `rdata` one cycle after the strobe, and clears output-buffer-full.
- R8: `a20_gate` equals output-port bit 1 and `cpu_reset` equals the inverse of output-port bit 0. Both change on the same edge as the port.
- R9: When a data read and a 0xD0 completion fall in the same cycle, the read returns the previous buffer byte. Output-buffer-full then stays set, and the new byte is held for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_cmd | input | 1 | 1 selects the command/status location, 0 the data location |
| wr_stb | input | 1 | Host write strobe, one cycle per byte |
| rd_stb | input | 1 | Host read strobe, one cycle per byte |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| port_q | output | 8 | Current output-port value |
| a20_gate | output | 1 | A20 enable (output-port bit 1) |
| cpu_reset | output | 1 | CPU reset request (inverse of output-port bit 0) |

## Verification
Two things can land on output-buffer-full in the same cycle. A host read of the data location clears it, while a completing 0xD0 command sets it and reloads the buffer. The bench leaves a stale byte in the buffer and then changes the port. It issues 0xD0 and times a data read so that its strobe meets the completion edge. The result is judged at the ports: the read must return the stale byte, status must still show output-buffer-full, and the next data read must return the new port value.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_PORT_READ  = 8'hD0;
  localparam logic [BYTE_W-1:0] OP_PORT_WRITE = 8'hD1;
  localparam logic [BYTE_W-1:0] PORT_RESET    = 8'hFF;

  localparam int ST_OBF_BIT = 0;
  localparam int ST_IBF_BIT = 1;

  localparam int PORT_NRST_BIT = 0;
  localparam int PORT_A20_BIT  = 1;

  typedef struct packed {
    logic                is_cmd;
    logic [BYTE_W-1:0]   val;
  } in_byte_t;
endpackage

// File: rtl/kbc_inbuf.sv
module kbc_inbuf #(
  parameter int CONSUME_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic               sel_cmd,
  input  logic [7:0]         wdata,
  output logic               ibf,
  output logic               done,
  output kbc_pkg::in_byte_t  held
);
  localparam int CW = (CONSUME_CYC > 1) ? $clog2(CONSUME_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CONSUME_CYC - 1);

  logic [CW-1:0] cnt;

  assign done = ibf && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ibf  <= 1'b0;
      cnt  <= '0;
      held <= '0;
    end else if (!ibf) begin
      if (wr_stb) begin
        ibf         <= 1'b1;
        cnt         <= LOAD;
        held.is_cmd <= sel_cmd;
        held.val    <= wdata;
      end
    end else if (cnt == '0) begin
      ibf <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/kbc_decode.sv
module kbc_decode (
  input  logic               clk,
  input  logic               rst,
  input  logic               done,
  input  kbc_pkg::in_byte_t  held,
  output logic               port_we,
  output logic [7:0]         port_wd,
  output logic               obuf_load
);
  import kbc_pkg::*;

  logic armed;

  assign port_we   = done && !held.is_cmd && armed;
  assign port_wd   = held.val;
  assign obuf_load = done && held.is_cmd && (held.val == OP_PORT_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (done) begin
      armed <= held.is_cmd && (held.val == OP_PORT_WRITE);
    end
  end
endmodule

// File: rtl/kbc_outport.sv
module kbc_outport (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wd,
  output logic [7:0] port_q,
  output logic       a20_gate,
  output logic       cpu_reset
);
  import kbc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q    <= PORT_RESET;
      a20_gate  <= PORT_RESET[PORT_A20_BIT];
      cpu_reset <= ~PORT_RESET[PORT_NRST_BIT];
    end else if (we) begin
      port_q    <= wd;
      a20_gate  <= wd[PORT_A20_BIT];
      cpu_reset <= ~wd[PORT_NRST_BIT];
    end
  end
endmodule

// File: rtl/kbc_outbuf.sv
module kbc_outbuf (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_stb,
  input  logic       sel_cmd,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       ibf,
  output logic       obf,
  output logic [7:0] rdata
);
  import kbc_pkg::*;

  logic [7:0] obuf;
  logic [7:0] status;

  always_comb begin
    status             = '0;
    status[ST_IBF_BIT] = ibf;
    status[ST_OBF_BIT] = obf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obf   <= 1'b0;
      obuf  <= '0;
      rdata <= '0;
    end else begin
      if (rd_stb) rdata <= sel_cmd ? status : obuf;
      if (load) begin
        obuf <= load_val;
        obf  <= 1'b1;
      end else if (rd_stb && !sel_cmd) begin
        obf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kbc_portctl.sv
module kbc_portctl #(
  parameter int CONSUME_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_cmd,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] port_q,
  output logic       a20_gate,
  output logic       cpu_reset
);
  kbc_pkg::in_byte_t held;
  logic              ibf;
  logic              done;
  logic              obf;
  logic              port_we;
  logic [7:0]        port_wd;
  logic              obuf_load;

  kbc_inbuf #(.CONSUME_CYC(CONSUME_CYC)) u_inbuf (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .sel_cmd(sel_cmd),
    .wdata(wdata), .ibf(ibf), .done(done), .held(held)
  );

  kbc_decode u_decode (
    .clk(clk), .rst(rst), .done(done), .held(held),
    .port_we(port_we), .port_wd(port_wd), .obuf_load(obuf_load)
  );

  kbc_outport u_outport (
    .clk(clk), .rst(rst), .we(port_we), .wd(port_wd),
    .port_q(port_q), .a20_gate(a20_gate), .cpu_reset(cpu_reset)
  );

  kbc_outbuf u_outbuf (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .sel_cmd(sel_cmd),
    .load(obuf_load), .load_val(port_q), .ibf(ibf),
    .obf(obf), .rdata(rdata)
  );
endmodule

// File: rtl/kbc_portctl_chk.sv
module kbc_portctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel_cmd,
  input logic       rd_stb,
  input logic       ibf,
  input logic       obf,
  input logic       done,
  input logic [7:0] port_q,
  input logic       a20_gate,
  input logic       cpu_reset
);
  // R8
  lines_track_chk: assert property (@(posedge clk) disable iff (rst)
    (a20_gate == port_q[1]) && (cpu_reset == !port_q[0]));

  // R5
  port_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(port_q) |-> ($past(ibf) && !ibf));

  // R4
  obf_from_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(obf) |-> $past(done));

  // R7
  obf_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !sel_cmd && !done) |=> !obf);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ibf && !done) |=> ibf);
endmodule

bind kbc_portctl kbc_portctl_chk u_chk (
  .clk(clk), .rst(rst), .sel_cmd(sel_cmd), .rd_stb(rd_stb),
  .ibf(ibf), .obf(obf), .done(done), .port_q(port_q),
  .a20_gate(a20_gate), .cpu_reset(cpu_reset)
);

// File: tb/tb_kbc_portctl.sv
`timescale 1ns/1ps
module tb_kbc_portctl;
  localparam int C = 4;
  localparam logic [1:0] WC = 2'd0, WD = 2'd1, RD = 2'd2, CK = 2'd3;
  localparam int NV = 19;
  // {op, data, expected}
  localparam logic [17:0] VEC [0:NV-1] = '{
    {WC, 8'hD1, 8'h00}, {WD, 8'hFD, 8'h00}, {CK, 8'h00, 8'hFD},
    {WC, 8'hD0, 8'h00}, {RD, 8'h00, 8'hFD},
    {WC, 8'hD1, 8'h00}, {WD, 8'hFE, 8'h00}, {CK, 8'h00, 8'hFE},
    {WC, 8'hD0, 8'h00}, {RD, 8'h00, 8'hFE},
    {WC, 8'hD1, 8'h00}, {WC, 8'hAA, 8'h00}, {WD, 8'h00, 8'h00},
    {CK, 8'h00, 8'hFE},
    {WD, 8'h12, 8'h00}, {CK, 8'h00, 8'hFE},
    {WC, 8'hD1, 8'h00}, {WD, 8'hFF, 8'h00}, {CK, 8'h00, 8'hFF}
  };

  logic clk = 0, rst = 1, sel_cmd = 0, wr_stb = 0, rd_stb = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, port_q;
  logic a20_gate, cpu_reset;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  kbc_portctl #(.CONSUME_CYC(C)) dut (
    .clk(clk), .rst(rst), .sel_cmd(sel_cmd), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata), .port_q(port_q),
    .a20_gate(a20_gate), .cpu_reset(cpu_reset)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic cmd, input logic [7:0] d);
    @(negedge clk); sel_cmd = cmd; wdata = d; wr_stb = 1;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic do_read(input logic cmd, output logic [7:0] v);
    @(negedge clk); sel_cmd = cmd; rd_stb = 1;
    @(negedge clk); rd_stb = 0; v = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 50; i++) begin
      do_read(1'b1, s);
      if (!s[1]) break;
    end
  endtask

  task automatic check_port(input logic [7:0] e, input string req);
    check(port_q == e && a20_gate == e[1] && cpu_reset == !e[0], req,
          {port_q, 6'b0, a20_gate, cpu_reset}, {e, 6'b0, e[1], !e[0]});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check_port(8'hFF, "R1");
    do_read(1'b1, v);
    check(v == 8'h00, "R1 status", v, 8'h00);

    // vector table: R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] d, e;
      {op, d, e} = VEC[i];
      case (op)
        WC: begin do_write(1'b1, d); wait_idle(); end
        WD: begin do_write(1'b0, d); wait_idle(); end
        RD: begin do_read(1'b0, v); check(v == e, "R4_R7 read", v, e); end
        default: check_port(e, "R5_R6_R8 port");
      endcase
    end

    // R3 busy window length: status read each cycle
    @(negedge clk); sel_cmd = 1; wdata = 8'h55; wr_stb = 1;
    @(negedge clk); wr_stb = 0; rd_stb = 1;
    n = 0;
    for (int k = 0; k < C + 4; k++) begin
      @(negedge clk);
      if (rdata[1]) n++;
    end
    rd_stb = 0;
    check(n == C, "R3 busy cycles", n, C);

    // R3 write while busy ignored
    @(negedge clk); sel_cmd = 1; wdata = 8'hD1; wr_stb = 1;
    @(negedge clk); sel_cmd = 0; wdata = 8'h00;
    @(negedge clk); wr_stb = 0;
    wait_idle();
    check_port(8'hFF, "R3 ignored write");
    do_write(1'b1, 8'hAA); wait_idle();

    // R2 status without side effects, R7 clear
    do_write(1'b1, 8'hD0); wait_idle();
    do_read(1'b1, v); check(v == 8'h01, "R2 status obf", v, 8'h01);
    do_read(1'b1, v); check(v == 8'h01, "R2 status repeat", v, 8'h01);
    do_read(1'b0, v); check(v == 8'hFF, "R7 data", v, 8'hFF);
    do_read(1'b1, v); check(v == 8'h00, "R7 obf cleared", v, 8'h00);

    // R9 same-cycle set and clear
    do_write(1'b1, 8'hD1); wait_idle();
    do_write(1'b0, 8'hFE); wait_idle();
    do_write(1'b1, 8'hD0); wait_idle();
    do_write(1'b1, 8'hD1); wait_idle();
    do_write(1'b0, 8'h7D); wait_idle();
    check_port(8'h7D, "R8 port 7D");
    @(negedge clk); sel_cmd = 1; wdata = 8'hD0; wr_stb = 1;
    @(negedge clk); wr_stb = 0;
    repeat (C - 1) @(negedge clk);
    sel_cmd = 0; rd_stb = 1;
    @(negedge clk); rd_stb = 0; v = rdata;
    check(v == 8'hFE, "R9 stale byte", v, 8'hFE);
    do_read(1'b1, v); check(v == 8'h01, "R9 obf kept", v, 8'h01);
    do_read(1'b0, v); check(v == 8'h7D, "R9 new byte", v, 8'h7D);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule